// File: doc/BRIEF.md
# PCM Codec Serial Timeslot Port

This block is the digital serial port of a telephony PCM codec. Frames repeat at 8 kHz, one every 125 µs, and each frame carries one 8-bit companded sample in each direction. On the transmit side the encoder hands over a byte on a parallel strobe. The byte waits in a holding register. At the next transmit frame sync it is shifted out MSB first on the serial data pin. A one-cycle request pulse at every sync tells the encoder to start its next sample. While the port is not sending a bit, the serial pin is marked high-impedance through an output-enable flag.

On the receive side a frame sync opens an 8-bit slot. The serial input is sampled on the falling edges of the next eight bit clocks. When the slot closes, the byte is presented on a parallel output with a one-cycle valid strobe, which also serves as the decode-start signal. The receive side may run from the same bit clock as the transmit side.

A law-select input chooses between two line formats. In A-law mode alternate bits of the code are inverted on the line. In mu-law mode the code goes out unchanged. The same inversion is removed on receive. Bit clocks, frame syncs and serial input are asynchronous to the block clock. They are synchronised and edge-detected inside the block, so the block clock must run several times faster than the bit clock.

Top module: `pcm_tsi`

## Requirements
- R1: During and straight after reset, `dx_oe`, `dx`, `rx_valid` and `tx_req` are all 0, and the holding register and received byte are 0.
- R2: A frame sync is detected on a falling bit-clock edge at which the sync input is high and was low at the previous falling edge. Each transmit sync produces exactly one `tx_req` pulse, one block clock wide.
- R3: After a transmit sync, the eight following rising bit-clock edges drive the byte MSB first on `dx`, with `dx_oe` high. `dx_oe` falls at the ninth rising edge. `dx` is 0 whenever `dx_oe` is 0.
- R4: A byte accepted on `enc_valid` goes out at the next transmit sync. This includes a byte accepted during the current slot, which does not alter the bits already being sent.
- R5: If no byte was accepted since the last sync, the previous holding-register contents are sent again.
- R6: With `law_sel`=1 (A-law) the line code is the byte XOR 8'h55, that is bits 6, 4, 2 and 0 inverted, with bit 7 sent first. With `law_sel`=0 (mu-law) the byte is sent unchanged.
- R7: After a receive sync, `dr` is sampled on the next eight falling bit-clock edges, MSB first, not on the sync edge itself. After the eighth sample, `rx_data` shows the byte with the R6 inversion removed and `rx_valid` pulses for one block clock.
- R8: A sync that arrives inside a slot restarts both directions. Transmit resends from the MSB of the newly loaded byte. Receive discards the partial byte, so only one `rx_valid` follows.
- R9: With both bit clocks tied together, both syncs tied together and `dx` looped to `dr`, every byte sent is received unchanged in either law.
- R10: `dx` and `dx_oe` change only in the block clock after a detected rising transmit bit-clock edge. `rx_valid` rises only in the block clock after a detected falling receive edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times faster than the bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | 1 = A-law line inversion, 0 = mu-law |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync pulse |
| enc_valid | input | 1 | Encoder byte strobe |
| enc_data | input | 8 | Encoder byte |
| tx_req | output | 1 | One-cycle start-of-sample request at each transmit sync |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Serial output enable, 0 means high-impedance |
| rx_bclk | input | 1 | Receive bit clock, may be tied to tx_bclk |
| rx_fsync | input | 1 | Receive frame sync pulse |
| dr | input | 1 | Serial receive data |
| rx_data | output | 8 | Received byte after law inversion is removed |
| rx_valid | output | 1 | One-cycle strobe: received byte ready, decode start |

## Verification
A wrong bit count shows within one frame. `dx_oe` stays high for more or fewer than eight bit times, or `rx_valid` comes at the wrong falling edge or not at all. A holding register that loads at the wrong moment breaks the one-frame latency. The error shows in the serial pattern of the frame in which the mid-slot load happens, or in the frame after it. A mask applied on one side only, or to the wrong bit positions, changes the captured serial pattern at once. A missing or doubled inversion also breaks the loopback byte in the same frame.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;

  localparam int MAX_W = 32;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;

  // Alternate-bit mask: LSB-indexed even positions set, up to width w.
  function automatic logic [MAX_W-1:0] alt_mask(input int w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < w && (i % 2) == 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pcm_tsi_sync.sv
module pcm_tsi_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/pcm_tsi_tx.sv
module pcm_tsi_tx
  import pcm_tsi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  law_e              law_sel,
  input  logic              bclk_s,
  input  logic              fsync_s,
  input  logic              enc_valid,
  input  logic [WORD_W-1:0] enc_data,
  output logic              tx_req,
  output logic              dx,
  output logic              dx_oe,
  output logic              rise_evt
);

  localparam int                CNT_W    = $clog2(WORD_W + 1);
  localparam logic [MAX_W-1:0]  MASK_ALL = alt_mask(WORD_W);
  localparam logic [CNT_W-1:0]  CNT_IDLE = CNT_W'(WORD_W);

  logic              bclk_q, bclk_d;
  logic              fs_q, fs_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] shf_q, shf_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dx_q, dx_d;
  logic              oe_q, oe_d;
  logic              req_q, req_d;

  logic              fall_evt;
  logic              sync_evt;
  logic [WORD_W-1:0] line_mask;

  assign rise_evt  = bclk_s & ~bclk_q;
  assign fall_evt  = ~bclk_s & bclk_q;
  assign sync_evt  = fall_evt & fsync_s & ~fs_q;
  assign line_mask = (law_sel == LAW_A) ? MASK_ALL[WORD_W-1:0] : '0;

  always_comb begin
    bclk_d = bclk_s;
    fs_d   = fall_evt ? fsync_s : fs_q;
    hold_d = enc_valid ? enc_data : hold_q;
    shf_d  = shf_q;
    cnt_d  = cnt_q;
    dx_d   = dx_q;
    oe_d   = oe_q;
    req_d  = sync_evt;

    if (sync_evt) begin
      // Sync takes the byte held before this edge; restarts any slot.
      shf_d = hold_q ^ line_mask;
      cnt_d = '0;
    end else if (rise_evt) begin
      if (cnt_q < CNT_IDLE) begin
        dx_d  = shf_q[WORD_W-1];
        oe_d  = 1'b1;
        shf_d = {shf_q[WORD_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end else begin
        dx_d = 1'b0;
        oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      hold_q <= '0;
      shf_q  <= '0;
      cnt_q  <= CNT_IDLE;
      dx_q   <= 1'b0;
      oe_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      fs_q   <= fs_d;
      hold_q <= hold_d;
      shf_q  <= shf_d;
      cnt_q  <= cnt_d;
      dx_q   <= dx_d;
      oe_q   <= oe_d;
      req_q  <= req_d;
    end
  end

  assign tx_req = req_q;
  assign dx     = dx_q;
  assign dx_oe  = oe_q;

endmodule

// File: rtl/pcm_tsi_rx.sv
module pcm_tsi_rx
  import pcm_tsi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  law_e              law_sel,
  input  logic              bclk_s,
  input  logic              fsync_s,
  input  logic              dr_s,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              fall_evt
);

  localparam int                CNT_W    = $clog2(WORD_W + 1);
  localparam logic [MAX_W-1:0]  MASK_ALL = alt_mask(WORD_W);
  localparam logic [CNT_W-1:0]  CNT_IDLE = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WORD_W - 1);

  logic              bclk_q, bclk_d;
  logic              fs_q, fs_d;
  logic [WORD_W-1:0] shf_q, shf_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;

  logic              sync_evt;
  logic [WORD_W-1:0] line_mask;
  logic [WORD_W-1:0] shf_next;

  assign fall_evt  = ~bclk_s & bclk_q;
  assign sync_evt  = fall_evt & fsync_s & ~fs_q;
  assign line_mask = (law_sel == LAW_A) ? MASK_ALL[WORD_W-1:0] : '0;
  assign shf_next  = {shf_q[WORD_W-2:0], dr_s};

  always_comb begin
    bclk_d = bclk_s;
    fs_d   = fall_evt ? fsync_s : fs_q;
    shf_d  = shf_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    vld_d  = 1'b0;

    if (sync_evt) begin
      cnt_d = '0;
    end else if (fall_evt && (cnt_q < CNT_IDLE)) begin
      shf_d = shf_next;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        data_d = shf_next ^ line_mask;
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      shf_q  <= '0;
      cnt_q  <= CNT_IDLE;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      fs_q   <= fs_d;
      shf_q  <= shf_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
  import pcm_tsi_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law_sel,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic              enc_valid,
  input  logic [WORD_W-1:0] enc_data,
  output logic              tx_req,
  output logic              dx,
  output logic              dx_oe,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              dr,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int N_ASYNC = 5;

  logic [N_ASYNC-1:0] async_in;
  logic [N_ASYNC-1:0] async_s;
  logic               tx_rise;
  logic               rx_fall;
  law_e               law;

  assign async_in = {tx_bclk, tx_fsync, rx_bclk, rx_fsync, dr};
  assign law      = law_e'(law_sel);

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      pcm_tsi_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (async_in),
        .d_out (async_s)
      );
    end else begin : g_bypass
      assign async_s = async_in;
    end
  endgenerate

  pcm_tsi_tx #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .law_sel   (law),
    .bclk_s    (async_s[4]),
    .fsync_s   (async_s[3]),
    .enc_valid (enc_valid),
    .enc_data  (enc_data),
    .tx_req    (tx_req),
    .dx        (dx),
    .dx_oe     (dx_oe),
    .rise_evt  (tx_rise)
  );

  pcm_tsi_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .law_sel  (law),
    .bclk_s   (async_s[2]),
    .fsync_s  (async_s[1]),
    .dr_s     (async_s[0]),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .fall_evt (rx_fall)
  );

endmodule

// File: rtl/pcm_tsi_chk.sv
module pcm_tsi_chk (
  input logic clk,
  input logic rst_n,
  input logic dx,
  input logic dx_oe,
  input logic tx_req,
  input logic rx_valid,
  input logic tx_rise,
  input logic rx_fall
);

  assert_dx_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  assert_rx_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_dx_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_rise) |-> ($stable(dx) && $stable(dx_oe)));

  assert_rx_valid_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_fall));

endmodule

bind pcm_tsi pcm_tsi_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dx       (dx),
  .dx_oe    (dx_oe),
  .tx_req   (tx_req),
  .rx_valid (rx_valid),
  .tx_rise  (tx_rise),
  .rx_fall  (rx_fall)
);

// File: tb/pcm_tsi_tb_top.sv
`timescale 1ns/1ps
module pcm_tsi_tb_top;

  logic       clk;
  logic       rst_n;
  logic       law_sel;
  logic       bclk;
  logic       fs;
  logic       enc_valid;
  logic [7:0] enc_data;
  logic       tx_req;
  logic       dx;
  logic       dx_oe;
  logic       dr;
  logic [7:0] rx_data;
  logic       rx_valid;

  int         n_chk;
  int         n_err;
  int         n_vld;
  int         n_req;
  logic [7:0] last_rx;
  logic [3:0] div;

  // R9: shared bit clock, shared sync, loopback with a pull-up on the line
  assign dr = dx_oe ? dx : 1'b1;

  pcm_tsi dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .law_sel   (law_sel),
    .tx_bclk   (bclk),
    .tx_fsync  (fs),
    .enc_valid (enc_valid),
    .enc_data  (enc_data),
    .tx_req    (tx_req),
    .dx        (dx),
    .dx_oe     (dx_oe),
    .rx_bclk   (bclk),
    .rx_fsync  (fs),
    .dr        (dr),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial div = '0;
  always @(posedge clk) div <= div + 4'd1;
  assign bclk = div[3];

  initial begin
    n_vld = 0; n_req = 0; last_rx = '0;
  end
  always @(posedge clk) begin
    if (rst_n && rx_valid) begin n_vld = n_vld + 1; last_rx = rx_data; end
    if (rst_n && tx_req) n_req = n_req + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] line_of(input logic a_law, input logic [7:0] b);
    return a_law ? (b ^ 8'h55) : b;
  endfunction

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    enc_valid = 1'b1;
    enc_data  = b;
    @(negedge clk);
    enc_valid = 1'b0;
  endtask

  task automatic run_frame(input bit mid_load, input logic [7:0] mid_byte,
                           output logic [7:0] ser, output int oe_cnt,
                           output logic oe_pre, output logic oe_post);
    oe_cnt = 0;
    @(posedge bclk); #1 fs = 1'b1;
    @(negedge bclk); #1 oe_pre = dx_oe;
    @(posedge bclk); #1 fs = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge bclk); #1;
      ser[7-k] = dx;
      if (dx_oe) oe_cnt++;
      if (mid_load && k == 3) load(mid_byte);
    end
    @(negedge bclk); #1 oe_post = dx_oe;
  endtask

  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'hD5}, {1'b0, 8'hD5}, {1'b1, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'h3C}, {1'b1, 8'hA7}, {1'b0, 8'h81}, {1'b1, 8'h5A}
  };

  bit done;

  initial begin
    logic [7:0] ser;
    logic [7:0] part;
    int         oec;
    logic       pre, post;
    int         v0, q0;

    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; law_sel = 1'b1; fs = 1'b0; enc_valid = 1'b0; enc_data = '0;
    repeat (5) @(posedge clk);
    #1;
    chk(!dx_oe && !dx && !rx_valid && !tx_req, "R1 outputs in reset",
        {dx_oe, dx, rx_valid, tx_req}, 0);
    chk(rx_data == 8'h00, "R1 rx_data in reset", rx_data, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(!dx_oe && !dx && n_vld == 0 && n_req == 0, "R1 idle after reset",
        {dx_oe, dx, n_vld[0], n_req[0]}, 0);

    // First frame: holding register is still 0
    v0 = n_vld;
    run_frame(0, 8'h00, ser, oec, pre, post);
    chk(ser == 8'h55, "R1 R6 reset hold sent as A-law zero", ser, 8'h55);
    chk(last_rx == 8'h00 && n_vld == v0 + 1, "R7 R9 reset byte received", last_rx, 0);

    // Table-driven loopback frames
    for (int i = 0; i < NV; i++) begin
      law_sel = VEC[i][8];
      load(VEC[i][7:0]);
      v0 = n_vld; q0 = n_req;
      run_frame(0, 8'h00, ser, oec, pre, post);
      chk(ser == line_of(VEC[i][8], VEC[i][7:0]), "R3 R6 serial pattern",
          ser, line_of(VEC[i][8], VEC[i][7:0]));
      chk(oec == 8 && !pre && !post, "R3 output enable window",
          {pre, oec[7:0], post}, {1'b0, 8'd8, 1'b0});
      chk(n_req == q0 + 1, "R2 one request per sync", n_req, q0 + 1);
      chk(n_vld == v0 + 1, "R7 one valid per slot", n_vld, v0 + 1);
      chk(last_rx == VEC[i][7:0], "R9 loopback byte", last_rx, VEC[i][7:0]);
    end

    // R5: nothing loaded, previous byte sent again
    law_sel = 1'b0;
    run_frame(0, 8'h00, ser, oec, pre, post);
    chk(ser == 8'h5A, "R5 retransmit of held byte", ser, 8'h5A);
    chk(last_rx == 8'h5A, "R5 retransmit received", last_rx, 8'h5A);

    // R4: byte loaded mid-slot waits for the next sync
    law_sel = 1'b1;
    load(8'h96);
    run_frame(1, 8'h3E, ser, oec, pre, post);
    chk(ser == line_of(1'b1, 8'h96), "R4 mid-slot load leaves current slot",
        ser, line_of(1'b1, 8'h96));
    run_frame(0, 8'h00, ser, oec, pre, post);
    chk(ser == line_of(1'b1, 8'h3E), "R4 mid-slot byte sent next frame",
        ser, line_of(1'b1, 8'h3E));
    chk(last_rx == 8'h3E, "R4 R7 next-frame byte received", last_rx, 8'h3E);

    // R8: sync inside a slot restarts both directions
    law_sel = 1'b0;
    load(8'hC3);
    v0 = n_vld; q0 = n_req;
    @(posedge bclk); #1 fs = 1'b1;
    @(posedge bclk); #1 fs = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge bclk); #1 part[7-k] = dx;
    end
    @(posedge bclk); #1 fs = 1'b1;
    @(posedge bclk); #1 fs = 1'b0;
    oec = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge bclk); #1;
      ser[7-k] = dx;
      if (dx_oe) oec++;
    end
    @(negedge bclk); #1 post = dx_oe;
    chk(part[7:5] == 3'b110, "R8 partial bits before restart", part[7:5], 3'b110);
    chk(ser == 8'hC3, "R8 full byte after restart", ser, 8'hC3);
    chk(oec == 8 && !post, "R8 enable window after restart", {oec[7:0], post}, {8'd8, 1'b0});
    chk(n_vld == v0 + 1, "R8 single valid after restart", n_vld, v0 + 1);
    chk(last_rx == 8'hC3, "R8 byte after restart", last_rx, 8'hC3);
    chk(n_req == q0 + 2, "R2 request per restart sync", n_req, q0 + 2);

    // R10: quiet line between slots
    repeat (40) @(negedge clk);
    chk(!dx_oe && !dx, "R10 R3 line idle between slots", {dx_oe, dx}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule